// File: doc/BRIEF.md
# Speculative Floating-Point Dispatch Queue

This block sits between an integer pipeline and a floating-point execution unit. In its second address-calculation cycle the integer side offers a floating-point instruction (an opcode plus a 64-bit operand). If no memory-management fault was found, the queue accepts it and hands back a checkpoint tag. The integer side may then keep retiring younger integer work speculatively. The queue holds up to four such instructions, passes them one by one to the execution unit over a valid/ready handshake, and keeps a speculation level equal to the number of live checkpoints.

The execution unit reports completions by tag. Only the oldest live entry may complete, so results and faults always reach the integer side in program order. A clean completion frees its checkpoint and is reported one cycle later. A faulting completion raises a one-cycle rollback carrying that entry's tag, discards every younger entry and empties the queue. A completion for any tag other than the oldest dispatched one is refused and flagged.

Top module: `fpq_dispatch`

## Requirements
- R1: An instruction offered with `ac_fault` high is never accepted: `acc_ok` stays low and `spec_level` does not rise.
- R2: Accepted instructions receive 2-bit tags in acceptance order. The tag is shown on `acc_tag` in the accept cycle, starts at 0 after reset, and wraps from 3 to 0.
- R3: At most four instructions are live. `int_stall` is high exactly while four are live, and an offer made then with no same-cycle clean completion is refused.
- R4: `spec_level` equals the number of live checkpoints. It rises by one on each accept and falls by one on each clean completion, as seen the cycle after.
- R5: With four entries live, a clean completion of the oldest and a new offer in the same cycle are both taken: `acc_ok` is high and `spec_level` stays 4.
- R6: `ex_valid` is high only while an accepted, not yet dispatched entry exists and no rollback is showing. Entries are presented oldest first with their opcode, operand and tag, and stay stable while `ex_ready` is low.
- R7: A completion whose tag is not the oldest live one, or that names an entry not yet dispatched, or that arrives with the queue empty, pulses `tag_err` in the next cycle and leaves `spec_level` unchanged.
- R8: A clean completion of the oldest entry pulses `done_valid` in the next cycle with that tag on `done_tag`. At most one of `done_valid`, `rb_valid` and `tag_err` is high in any cycle.
- R9: A completion of the oldest entry with `cmp_exc` high pulses `rb_valid` in the next cycle with its tag on `rb_tag`. In that cycle `spec_level` is 0 and `ex_valid` is low. No offer is accepted in the completion cycle or the rollback cycle, and the next accepted instruction takes the tag that follows the last one issued before the rollback.
- R10: After reset the queue is empty: `spec_level` 0, `int_stall`, `ex_valid`, `done_valid`, `rb_valid` and `tag_err` low, and `acc_tag` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ac_valid | input | 1 | Instruction offered from the address stage |
| ac_fault | input | 1 | Memory-management fault found for the offered instruction |
| ac_op | input | OP_W | Opcode of the offered instruction |
| ac_data | input | DATA_W | 64-bit operand of the offered instruction |
| acc_ok | output | 1 | Offer accepted this cycle |
| acc_tag | output | TAG_W | Checkpoint tag given to the offer |
| int_stall | output | 1 | Queue full; stop issuing floating-point work |
| spec_level | output | TAG_W+1 | Number of live checkpoints |
| ex_valid | output | 1 | Entry presented to the execution unit |
| ex_ready | input | 1 | Execution unit takes the presented entry |
| ex_op | output | OP_W | Opcode of the presented entry |
| ex_data | output | DATA_W | Operand of the presented entry |
| ex_tag | output | TAG_W | Tag of the presented entry |
| cmp_valid | input | 1 | Execution unit reports a completion |
| cmp_tag | input | TAG_W | Tag of the completed entry |
| cmp_exc | input | 1 | The completion carries an exception |
| done_valid | output | 1 | In-order clean completion reported |
| done_tag | output | TAG_W | Tag of the reported completion |
| rb_valid | output | 1 | Rollback to a checkpoint |
| rb_tag | output | TAG_W | Checkpoint tag to restore |
| tag_err | output | 1 | Out-of-order or unknown completion refused |

## Verification
The three pointers carry all of the queue's state, so any slip among them shows at the ports within a cycle or two. A lost or doubled retire step moves `spec_level` and `int_stall` on the very next cycle. It also makes the following in-order completion come back as `tag_err` where a `done_valid` was due. A wrong issue pointer shows up as an entry presented out of order or twice, which the dispatch scoreboard catches at the handshake. A flush that fails to realign the pointers leaves `spec_level` nonzero during the rollback pulse, or gives the next instruction a tag out of sequence.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

  // Outcome of a completion report from the execution unit.
  typedef enum logic [1:0] {
    CMP_NONE   = 2'd0,
    CMP_RETIRE = 2'd1,
    CMP_FLUSH  = 2'd2,
    CMP_BAD    = 2'd3
  } cmp_kind_e;

endpackage

// File: rtl/fpq_store.sv
module fpq_store #(
  parameter  int DEPTH  = 4,
  parameter  int OP_W   = 16,
  parameter  int DATA_W = 64,
  localparam int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_idx,
  input  logic [OP_W-1:0]   wr_op,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  rd_idx,
  output logic [OP_W-1:0]   rd_op,
  output logic [DATA_W-1:0] rd_data
);

  logic [OP_W-1:0]   op_mem   [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  // Payload slots carry no reset; occupancy lives in the pointer logic.
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == TAG_W'(s));

    always_ff @(posedge clk) begin
      if (slot_en) begin
        op_mem[s]   <= wr_op;
        data_mem[s] <= wr_data;
      end
    end
  end

  assign rd_op   = op_mem[rd_idx];
  assign rd_data = data_mem[rd_idx];

endmodule

// File: rtl/fpq_ctrl.sv
module fpq_ctrl
  import fpq_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ac_valid,
  input  logic             ac_fault,
  input  logic             rb_busy,
  input  logic             ex_ready,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             cmp_exc,
  output logic             accept,
  output logic [TAG_W-1:0] wr_tag,
  output logic [TAG_W-1:0] iss_tag,
  output logic [TAG_W-1:0] head_tag,
  output logic             ex_valid,
  output logic             full,
  output logic [PTR_W-1:0] level,
  output cmp_kind_e        kind
);

  // wr: next tag to hand out; rd: oldest live checkpoint; iss: next to dispatch.
  logic [PTR_W-1:0] wr_q, rd_q, iss_q;
  logic [PTR_W-1:0] wr_d, rd_d, iss_d;
  logic             tag_ok, retire, flush, issue, ptr_en;

  assign level    = wr_q - rd_q;
  assign full     = (level == PTR_W'(DEPTH));
  assign ex_valid = (iss_q != wr_q) && !rb_busy;
  assign issue    = ex_valid && ex_ready;

  // Only the oldest entry, and only once it has been dispatched, may complete.
  assign tag_ok = cmp_valid && (iss_q != rd_q) && (cmp_tag == rd_q[TAG_W-1:0]);
  assign retire = tag_ok && !cmp_exc;
  assign flush  = tag_ok && cmp_exc;

  assign accept = ac_valid && !ac_fault && !rb_busy && !flush && (!full || retire);

  always_comb begin
    if (flush)          kind = CMP_FLUSH;
    else if (retire)    kind = CMP_RETIRE;
    else if (cmp_valid) kind = CMP_BAD;
    else                kind = CMP_NONE;
  end

  always_comb begin
    wr_d  = wr_q + PTR_W'(accept);
    rd_d  = rd_q + PTR_W'(retire);
    iss_d = iss_q + PTR_W'(issue);
    if (flush) begin
      rd_d  = wr_q;
      iss_d = wr_q;
    end
  end

  assign ptr_en = accept || issue || retire || flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      iss_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      iss_q <= iss_d;
    end
  end

  assign wr_tag   = wr_q[TAG_W-1:0];
  assign iss_tag  = iss_q[TAG_W-1:0];
  assign head_tag = rd_q[TAG_W-1:0];

  // R3: live checkpoints never exceed the queue depth.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PTR_W'(DEPTH));

  // R3: the dispatch pointer stays between the oldest and the newest entry.
  a_r3_iss_window: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_q - rd_q) <= level);

  // R4: a clean completion with no offer taken drops the level by one.
  a_r4_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !accept) |=> level == $past(level) - PTR_W'(1));

  // R5: a full queue that retires and accepts together stays full.
  a_r5_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (full && retire && accept) |=> full);

  // R9: a flush leaves no live checkpoint behind.
  a_r9_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0);

endmodule

// File: rtl/fpq_report.sv
module fpq_report
  import fpq_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmp_kind_e        kind,
  input  logic [TAG_W-1:0] head_tag,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output logic             tag_err
);

  logic done_d, rb_d, err_d, done_en, rb_en;

  always_comb begin
    done_d  = (kind == CMP_RETIRE);
    rb_d    = (kind == CMP_FLUSH);
    err_d   = (kind == CMP_BAD);
    done_en = done_d;
    rb_en   = rb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      rb_valid   <= 1'b0;
      tag_err    <= 1'b0;
    end else begin
      done_valid <= done_d;
      rb_valid   <= rb_d;
      tag_err    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_tag <= '0;
    end else if (done_en) begin
      done_tag <= head_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_tag <= '0;
    end else if (rb_en) begin
      rb_tag <= head_tag;
    end
  end

  // R8: one completion input yields at most one report per cycle.
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_valid, rb_valid, tag_err}));

endmodule

// File: rtl/fpq_dispatch.sv
module fpq_dispatch
  import fpq_pkg::*;
#(
  parameter  int DEPTH  = 4,
  parameter  int OP_W   = 16,
  parameter  int DATA_W = 64,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int LVL_W  = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ac_valid,
  input  logic              ac_fault,
  input  logic [OP_W-1:0]   ac_op,
  input  logic [DATA_W-1:0] ac_data,
  output logic              acc_ok,
  output logic [TAG_W-1:0]  acc_tag,
  output logic              int_stall,
  output logic [LVL_W-1:0]  spec_level,
  output logic              ex_valid,
  input  logic              ex_ready,
  output logic [OP_W-1:0]   ex_op,
  output logic [DATA_W-1:0] ex_data,
  output logic [TAG_W-1:0]  ex_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic              cmp_exc,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag,
  output logic              tag_err
);

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [TAG_W-1:0] wr_tag, iss_tag, head_tag;
  logic             accept, full;
  cmp_kind_e        kind;

  fpq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ac_valid (ac_valid),
    .ac_fault (ac_fault),
    .rb_busy  (rb_valid),
    .ex_ready (ex_ready),
    .cmp_valid(cmp_valid),
    .cmp_tag  (cmp_tag),
    .cmp_exc  (cmp_exc),
    .accept   (accept),
    .wr_tag   (wr_tag),
    .iss_tag  (iss_tag),
    .head_tag (head_tag),
    .ex_valid (ex_valid),
    .full     (full),
    .level    (spec_level),
    .kind     (kind)
  );

  fpq_store #(.DEPTH(DEPTH), .OP_W(OP_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .wr_en  (accept),
    .wr_idx (wr_tag),
    .wr_op  (ac_op),
    .wr_data(ac_data),
    .rd_idx (iss_tag),
    .rd_op  (ex_op),
    .rd_data(ex_data)
  );

  fpq_report #(.TAG_W(TAG_W)) u_report (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .kind      (kind),
    .head_tag  (head_tag),
    .done_valid(done_valid),
    .done_tag  (done_tag),
    .rb_valid  (rb_valid),
    .rb_tag    (rb_tag),
    .tag_err   (tag_err)
  );

  assign acc_ok    = accept;
  assign acc_tag   = wr_tag;
  assign int_stall = full;
  assign ex_tag    = iss_tag;

  // R1: a faulting offer never raises the speculation level.
  a_r1_fault_dropped: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ac_fault && !(cmp_valid && cmp_tag == head_tag)) |=> spec_level <= $past(spec_level));

  // R6: a presented entry holds still until taken.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ex_valid && !ex_ready && kind != CMP_FLUSH)
      |=> ex_valid && $stable(ex_tag) && $stable(ex_data) && $stable(ex_op));

  // R7: a refused completion leaves the level untouched unless an offer was taken.
  a_r7_bad_no_move: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind == CMP_BAD && !accept) |=> spec_level == $past(spec_level));

  // R9: while a rollback shows, the queue is empty and nothing is dispatched.
  a_r9_rollback_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    rb_valid |-> (spec_level == '0) && !ex_valid && !acc_ok);

endmodule

// File: tb/fpq_dispatch_test.sv
module fpq_dispatch_test;

  localparam int OP_W   = 16;
  localparam int DATA_W = 64;

  typedef struct {
    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] data;
    logic [1:0]        tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ac_valid, ac_fault;
  logic [OP_W-1:0]   ac_op;
  logic [DATA_W-1:0] ac_data;
  logic              acc_ok;
  logic [1:0]        acc_tag;
  logic              int_stall;
  logic [2:0]        spec_level;
  logic              ex_valid, ex_ready;
  logic [OP_W-1:0]   ex_op;
  logic [DATA_W-1:0] ex_data;
  logic [1:0]        ex_tag;
  logic              cmp_valid, cmp_exc;
  logic [1:0]        cmp_tag;
  logic              done_valid, rb_valid, tag_err;
  logic [1:0]        done_tag, rb_tag;

  int    checks = 0;
  int    fails  = 0;
  bit    live   = 1'b0;
  bit    ended  = 1'b0;
  item_t sb[$];

  always #4 clk = ~clk;

  fpq_dispatch uut (
    .clk(clk), .rst_n(rst_n),
    .ac_valid(ac_valid), .ac_fault(ac_fault), .ac_op(ac_op), .ac_data(ac_data),
    .acc_ok(acc_ok), .acc_tag(acc_tag), .int_stall(int_stall), .spec_level(spec_level),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_op(ex_op), .ex_data(ex_data), .ex_tag(ex_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_exc(cmp_exc),
    .done_valid(done_valid), .done_tag(done_tag),
    .rb_valid(rb_valid), .rb_tag(rb_tag), .tag_err(tag_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [OP_W-1:0] op, input logic [DATA_W-1:0] d, input logic f);
    ac_valid = 1'b1; ac_fault = f; ac_op = op; ac_data = d;
  endtask

  task automatic idle();
    ac_valid = 1'b0; ac_fault = 1'b0; cmp_valid = 1'b0; cmp_exc = 1'b0;
  endtask

  task automatic complete(input logic [1:0] t, input logic e);
    cmp_valid = 1'b1; cmp_tag = t; cmp_exc = e;
  endtask

  // Driver side of the scoreboard: an accepted offer becomes an expected dispatch.
  task automatic expect_push(input logic [1:0] t);
    item_t it;
    it.op = ac_op; it.data = ac_data; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Monitor: every handshake must match the oldest expected dispatch (R6).
  always @(negedge clk) begin : mon
    item_t got;
    #3;
    if (live && ex_valid && ex_ready) begin
      if (sb.size() == 0) begin
        chk("R6 unexpected dispatch", 64'(ex_tag), 64'hdead);
      end else begin
        got = sb.pop_front();
        chk("R6 dispatch tag", 64'(ex_tag), 64'(got.tag));
        chk("R6 dispatch op", 64'(ex_op), 64'(got.op));
        chk("R6 dispatch data", ex_data, got.data);
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin : main
    idle();
    ex_ready = 1'b0; cmp_tag = 2'd0; ac_op = '0; ac_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    live = 1'b1;

    // R10: reset state
    #1;
    chk("R10 spec_level", 64'(spec_level), 0);
    chk("R10 int_stall", 64'(int_stall), 0);
    chk("R10 ex_valid", 64'(ex_valid), 0);
    chk("R10 reports", 64'({done_valid, rb_valid, tag_err}), 0);
    chk("R10 acc_tag", 64'(acc_tag), 0);

    // R1: faulting offer dropped
    @(negedge clk);
    put(16'hbad0, 64'hffff_0000_ffff_0000, 1'b1);
    #1 chk("R1 acc_ok", 64'(acc_ok), 0);
    @(negedge clk); idle();
    #1 chk("R1 spec_level", 64'(spec_level), 0);

    // R2/R4: fill four entries
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      put(16'h1000 + 16'(i), 64'h0123_4567_89ab_0000 + 64'(i * 17), 1'b0);
      #1;
      chk("R2 acc_ok", 64'(acc_ok), 1);
      chk("R2 acc_tag", 64'(acc_tag), 64'(i));
      chk("R4 level before accept", 64'(spec_level), 64'(i));
      if (acc_ok) expect_push(acc_tag);
    end
    @(negedge clk); idle();
    #1;
    chk("R4 level full", 64'(spec_level), 4);
    chk("R3 int_stall", 64'(int_stall), 1);
    chk("R6 head op", 64'(ex_op), 64'h1000);
    chk("R6 ex_valid", 64'(ex_valid), 1);

    // R3: fifth offer refused while full
    @(negedge clk);
    put(16'h2222, 64'h2222, 1'b0);
    #1 chk("R3 refuse when full", 64'(acc_ok), 0);
    @(negedge clk); idle();
    #1;
    chk("R3 level stays", 64'(spec_level), 4);
    chk("R6 held op", 64'(ex_op), 64'h1000);
    chk("R6 held tag", 64'(ex_tag), 0);

    // R6: drain to execution unit
    @(negedge clk); ex_ready = 1'b1;
    repeat (5) @(negedge clk);
    #1 chk("R6 nothing left", 64'(ex_valid), 0);

    // R7: completion not naming the oldest
    @(negedge clk); complete(2'd1, 1'b0);
    @(negedge clk); idle();
    #1;
    chk("R7 tag_err", 64'(tag_err), 1);
    chk("R7 no done", 64'(done_valid), 0);
    chk("R7 level", 64'(spec_level), 4);

    // R5: full, complete oldest and accept together; tag wraps (R2)
    @(negedge clk);
    complete(2'd0, 1'b0);
    put(16'h3333, 64'hcafe_f00d_0000_3333, 1'b0);
    #1;
    chk("R5 acc_ok", 64'(acc_ok), 1);
    chk("R2 wrap tag", 64'(acc_tag), 0);
    if (acc_ok) expect_push(acc_tag);
    @(negedge clk); idle();
    #1;
    chk("R5 level", 64'(spec_level), 4);
    chk("R8 done_valid", 64'(done_valid), 1);
    chk("R8 done_tag", 64'(done_tag), 0);

    // R4/R8: clean completion
    @(negedge clk); complete(2'd1, 1'b0);
    @(negedge clk); idle();
    #1;
    chk("R8 done_tag", 64'(done_tag), 1);
    chk("R4 level drop", 64'(spec_level), 3);

    // R9: exception at head with a same-cycle offer
    @(negedge clk);
    complete(2'd2, 1'b1);
    put(16'h4444, 64'h4444_4444, 1'b0);
    #1 chk("R9 no accept in flush", 64'(acc_ok), 0);
    @(negedge clk);
    cmp_valid = 1'b0; cmp_exc = 1'b0; ex_ready = 1'b0;
    #1;
    chk("R9 rb_valid", 64'(rb_valid), 1);
    chk("R9 rb_tag", 64'(rb_tag), 2);
    chk("R9 level", 64'(spec_level), 0);
    chk("R9 ex_valid", 64'(ex_valid), 0);
    chk("R9 no accept in rollback", 64'(acc_ok), 0);
    chk("R8 no done", 64'(done_valid), 0);
    sb.delete();
    @(negedge clk);
    #1;
    chk("R9 accept after", 64'(acc_ok), 1);
    chk("R9 tag continues", 64'(acc_tag), 1);
    if (acc_ok) expect_push(acc_tag);
    @(negedge clk); idle();
    #1;
    chk("R9 rollback over", 64'(rb_valid), 0);
    chk("R4 level", 64'(spec_level), 1);

    // R7: completion for an entry not yet dispatched
    @(negedge clk); complete(2'd1, 1'b0);
    @(negedge clk); idle();
    #1;
    chk("R7 undispatched", 64'(tag_err), 1);
    chk("R7 level kept", 64'(spec_level), 1);

    // dispatch it, then complete
    ex_ready = 1'b1;
    @(negedge clk); complete(2'd1, 1'b0);
    @(negedge clk); idle();
    #1;
    chk("R8 done after dispatch", 64'(done_valid), 1);
    chk("R8 tag", 64'(done_tag), 1);
    chk("R4 empty", 64'(spec_level), 0);

    // R7: completion while empty
    @(negedge clk); complete(2'd2, 1'b0);
    @(negedge clk); idle();
    #1;
    chk("R7 empty", 64'(tag_err), 1);
    chk("R3 no stall", 64'(int_stall), 0);
    chk("R6 scoreboard drained", 64'(sb.size()), 0);

    repeat (2) @(negedge clk);
    summary();
  end

endmodule